// File: doc/BRIEF.md
# SPI Multiplexed Port Expander

This block is an SPI slave that lets a host refresh up to 256 digital outputs and read up to 256 digital inputs. These sit behind sixteen external 16-way multiplexer modules that share one 4-bit channel-select bus. Each 16-bit word the host shifts in carries one output level per module for the currently selected channel. The word shifted back carries one sampled input level per module for that same channel.

The channel is never addressed explicitly. An internal word counter drives the select bus and moves on by one after every completed word, so sixteen consecutive words cover every channel of every module. After the last channel the counter returns to channel 0 by itself, so the host can stream frames without a break. A separate frame-reset pin forces the counter back to channel 0 at any time.

All host-side pins are brought into the system clock domain through two-flop synchronizers. The SCK rate must therefore stay well below the system clock; the bench uses a half period of eight system clocks.

Top module: `spi_port_expander`

## Requirements
- R1: After the system reset `rst_ni`, `sel_o` is 0, `dout_o` is all zeros and `miso_o` is 0.
- R2: The bus uses SPI mode 0: MOSI is captured on the rising SCK edge, the most significant bit comes first, and `cs_ni` is active low. When the 16th bit of a word arrives, that word appears on `dout_o`, with bit k going to module k's output mux.
- R3: `dout_o` stays unchanged while a word is being shifted in. It changes only when a word completes.
- R4: The word returned on `miso_o` (MSB first, valid before each rising SCK edge) equals `din_i` as sampled when `cs_ni` falls. Bit k is module k's input level on the channel selected for that word.
- R5: `sel_o` advances by one after each completed word and wraps from 15 to 0.
- R6: If `cs_ni` goes high before the 16th bit, the partial word is discarded. `sel_o` and `dout_o` are left unchanged, and the next transfer starts again at its first bit.
- R7: While `frame_rst_i` is high, the word counter is held at channel 0. `dout_o` is not affected. The next word returns channel-0 inputs and drives channel-0 outputs.
- R8: Several words may follow one another inside one `cs_ni` low period. For each word after the first, the inputs are sampled on the SCK falling edge that ends the previous word, after `sel_o` has moved on.
- R9: While `cs_ni` is high, `miso_o` is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| sck_i | input | 1 | SPI serial clock from host |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| frame_rst_i | input | 1 | Word counter clear, active high |
| sel_o | output | 4 | Shared mux channel select |
| dout_o | output | 16 | Output level per module for the selected channel |
| din_i | input | 16 | Input level per module for the selected channel |

## Verification
Because the bench models the external multiplexers as a function of `sel_o`, a counter that skips a step, fails to wrap or ignores the frame reset shows up at once in the next returned word. It also shows up on `sel_o` within a few clocks of the word boundary. A bit counter that is not cleared when a transfer is aborted misaligns the following word, and the first full word after the abort then returns wrong data. A mistimed output latch is visible on `dout_o` in the middle of a word, or one word late.

// File: rtl/pex_pkg.sv
package pex_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned N_CH     = 16;
  localparam int unsigned SYNC_LEN = 2;
endpackage

// File: rtl/pex_sync.sv
module pex_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) ff_q[i] <= RST_VAL;
    end else begin
      ff_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pex_shift.sv
module pex_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [WORD_W-1:0] par_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o,
  output logic              miso_o
);
  localparam int unsigned BC_W = $clog2(WORD_W);

  logic              sck_d, cs_d, done_q;
  logic [BC_W-1:0]   bit_q;
  logic [WORD_W-1:0] rx_q, tx_q, word_q;
  logic              act, sck_rise, sck_fall, cs_fall, last_bit;

  assign act      = !cs_ni;
  assign sck_rise = act && sck_i && !sck_d;
  assign sck_fall = act && !sck_i && sck_d;
  assign cs_fall  = !cs_ni && cs_d;
  assign last_bit = (bit_q == BC_W'(WORD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
      done_q <= 1'b0;
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      word_q <= '0;
    end else begin
      sck_d  <= sck_i;
      cs_d   <= cs_ni;
      done_q <= 1'b0;
      if (!act) begin
        bit_q <= '0;  // abort drops any partial word
      end else if (sck_rise) begin
        rx_q  <= {rx_q[WORD_W-2:0], mosi_i};
        bit_q <= last_bit ? '0 : bit_q + 1'b1;
        if (last_bit) begin
          word_q <= {rx_q[WORD_W-2:0], mosi_i};
          done_q <= 1'b1;
        end
      end
      if (cs_fall) tx_q <= par_i;
      else if (sck_fall) tx_q <= (bit_q == '0) ? par_i : {tx_q[WORD_W-2:0], 1'b0};
    end
  end

  assign word_o = word_q;
  assign done_o = done_q;
  assign miso_o = act && tx_q[WORD_W-1];

  p_abort_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |=> (bit_q == '0));
  p_single_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_load_on_select_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> (tx_q == $past(par_i)));
endmodule

// File: rtl/pex_chan_ctr.sv
module pex_chan_ctr #(
  parameter int unsigned N_CH = 16,
  localparam int unsigned SEL_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             clr_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (clr_i)  sel_q <= '0;
    else if (adv_i)  sel_q <= (sel_q == SEL_W'(N_CH - 1)) ? '0 : sel_q + 1'b1;
  end

  assign sel_o = sel_q;

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i) |=> (sel_q == (($past(sel_q) == SEL_W'(N_CH - 1)) ? '0 : $past(sel_q) + 1'b1)));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(sel_q));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sel_q == '0));
endmodule

// File: rtl/spi_port_expander.sv
module spi_port_expander
  import pex_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        cs_ni,
  input  logic        mosi_i,
  output logic        miso_o,
  input  logic        frame_rst_i,
  output logic [3:0]  sel_o,
  output logic [15:0] dout_o,
  input  logic [15:0] din_i
);
  localparam int unsigned SEL_W = $clog2(N_CH);

  logic [3:0]        pins_s;
  logic              sck_s, cs_s, mosi_s, frst_s, done;
  logic [WORD_W-1:0] word, dout_q;
  logic [SEL_W-1:0]  sel;

  pex_sync #(.W(4), .STAGES(SYNC_LEN), .RST_VAL(4'b0100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({frame_rst_i, cs_ni, mosi_i, sck_i}),
    .q_o    (pins_s)
  );
  assign {frst_s, cs_s, mosi_s, sck_s} = pins_s;

  pex_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_s),
    .cs_ni  (cs_s),
    .mosi_i (mosi_s),
    .par_i  (din_i),
    .word_o (word),
    .done_o (done),
    .miso_o (miso_o)
  );

  pex_chan_ctr #(.N_CH(N_CH)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (done),
    .clr_i  (frst_s),
    .sel_o  (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_q <= '0;
    else if (done) dout_q <= word;
  end

  assign dout_o = dout_q;
  assign sel_o  = sel;

  p_dout_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(dout_o));
  p_dout_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (dout_o == $past(word)));
  p_miso_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !miso_o);
endmodule

// File: tb/spi_port_expander_tb.sv
module spi_port_expander_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, frame_rst = 1'b0;
  logic miso;
  logic [3:0]  sel;
  logic [15:0] dout, din;
  int checks = 0, fails = 0, exp_ch = 0;
  logic [15:0] exp_dout = '0;

  always #(CLK_P/2) clk = ~clk;

  spi_port_expander u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .frame_rst_i(frame_rst), .sel_o(sel), .dout_o(dout), .din_i(din)
  );

  function automatic logic [15:0] pat(input int c);
    int v;
    v = ((c + 1) * 32'h1357) ^ 32'hF00F;
    return v[15:0];
  endfunction

  always_comb din = pat(int'(sel));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [15:0] w, input int nbits, input bit mid, output logic [15:0] r);
    r = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = w[15-i];
      tick(HALF);
      r[15-i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
      if (mid && i == 7) chk("R3 dout mid-word", dout, exp_dout);
    end
  endtask

  task automatic word(input logic [15:0] w, input bit mid);
    logic [15:0] r;
    shift_bits(w, 16, mid, r);
    chk("R4 returned word", r, pat(exp_ch));
    exp_dout = w;
    exp_ch   = (exp_ch + 1) % 16;
    chk("R2 dout after word", dout, exp_dout);
    chk("R5 sel advance", sel, exp_ch);
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 sel", sel, 0);
    chk("R1 dout", dout, 0);
    chk("R1 miso", miso, 0);
  endtask

  task automatic t_single();
    cs_n = 1'b0; tick(HALF);
    word(16'hBEEF, 1'b1);
    cs_n = 1'b1; tick(HALF);
    chk("R9 miso idle", miso, 0);
  endtask

  task automatic t_burst();
    cs_n = 1'b0; tick(HALF);
    for (int k = 0; k < 17; k++) word(16'h8001 ^ (16'h0F1E * k[15:0]), k == 3);
    cs_n = 1'b1; tick(HALF);
    chk("R8 R5 wrapped sel", sel, exp_ch);
  endtask

  task automatic t_abort();
    logic [15:0] r;
    cs_n = 1'b0; tick(HALF);
    shift_bits(16'hFFFF, 7, 1'b0, r);
    cs_n = 1'b1; tick(HALF);
    chk("R6 sel kept", sel, exp_ch);
    chk("R6 dout kept", dout, exp_dout);
    cs_n = 1'b0; tick(HALF);
    word(16'h1234, 1'b0);
    cs_n = 1'b1; tick(HALF);
  endtask

  task automatic t_frame_rst();
    cs_n = 1'b0; tick(HALF);
    word(16'h0F0F, 1'b0);
    word(16'hF0F0, 1'b0);
    cs_n = 1'b1; tick(HALF);
    frame_rst = 1'b1; tick(6);
    frame_rst = 1'b0; tick(4);
    exp_ch = 0;
    chk("R7 sel cleared", sel, 0);
    chk("R7 dout untouched", dout, exp_dout);
    cs_n = 1'b0; tick(HALF);
    word(16'h5A5A, 1'b0);
    cs_n = 1'b1; tick(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog timeout act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(4);
    rst_ni = 1'b1;
    t_reset();
    t_single();
    t_burst();
    t_abort();
    t_frame_rst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule